// File: doc/BRIEF.md
# Burst SRAM Cycle and Byte-Write Control

This block sits between the pins of a synchronous burst SRAM and its storage. On every rising clock edge it decides whether a burst begins, continues or ends. It also decides which byte lanes of the current word are written, whether write data is loaded, whether the address sequencer should step, and whether the data bus may be driven. The word address comes from an external address sequencer. The storage is a small lane-split array inside the block, and read data flows through from the array without an extra register.

A burst can begin in two ways. A processor-strobe start is always a read. A controller-strobe start samples the write controls on that same edge. Once a burst is open, an edge with both strobes high continues it. On such an edge the byte strobes and the advance input are honoured. A strobe edge that finds the chip deselected closes the burst. After that the bus stays undriven and no writes occur until a new burst is opened.

Top module: `bsram_cycle_ctl`

## Requirements
- R1: On an edge where the processor strobe is low and the chip is selected, `byte_we` is 4'b0000 and `din_load` is 0, whatever the global, byte and lane write inputs and the controller strobe are.
- R2: On a write-capable edge with `gwe_n` low, `byte_we` is 4'b1111, whatever `bwe_n` and `lane_n` are. A write-capable edge is either a controller start (controller strobe low, processor strobe high, selected) or a continuation (both strobes high, burst open).
- R3: On a write-capable edge with `gwe_n` high, `byte_we[i]` is 1 exactly when `bwe_n` is low and `lane_n[i]` is low. Lane 0 covers data bits 7:0 and lane 3 covers bits 31:24.
- R4: A controller-strobe start writes on its own edge, using the address presented on that edge. If both strobes are low, the edge counts as a processor start.
- R5: `din_load` is 1 exactly on edges where `byte_we` is nonzero.
- R6: `burst_adv` is 1 exactly on continuation edges that sample `adv_n` low.
- R7: `dq_oe` is 1 only when a burst is open, `oe_n` is low, and the most recent edge wrote no lane. The "most recent edge wrote no lane" condition applies even while `oe_n` is low.
- R8: `dout` always shows the word stored at `wa` with no register on the way. After a write edge, only the enabled lanes of that word hold the new data.
- R9: A strobe edge that samples the chip deselected closes the burst. `dq_oe` is then 0, and later continuation edges write nothing until a new start.
- R10: After reset no burst is open, `dq_oe` is 0, and a both-strobes-high edge writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| p_strobe_n | input | 1 | Processor address strobe, active low (read start) |
| c_strobe_n | input | 1 | Controller address strobe, active low (read or write start) |
| adv_n | input | 1 | Burst advance request, active low |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| lane_n | input | 4 | Per-lane write strobes, active low, bit 0 = bits 7:0 |
| oe_n | input | 1 | Output enable, active low |
| sel | input | 1 | Chip-select status, high when selected |
| wa | input | 4 | Word address from the address sequencer |
| din | input | 32 | Write data from the bus |
| dout | output | 32 | Flow-through read data of word `wa` |
| dq_oe | output | 1 | Data bus output-buffer enable |
| byte_we | output | 4 | Per-lane array write enables for this edge |
| din_load | output | 1 | Data-in register load for this edge |
| burst_adv | output | 1 | Step request to the address sequencer |

## Verification
The bench first fills every word with a global write. It then sweeps all 64 combinations of global enable, byte enable and lane strobes three times: on controller starts, on continuation edges and on processor starts. This separates the precedence of the global enable, the per-lane AND with the byte enable, and the suppression of writes on processor starts. After each edge it reads the word back through the flow-through output and checks the bus enable against both the output enable and the previous edge's write activity. Extra sequences cover a deselected strobe, both strobes low together, and continuation edges with and without advance.

// File: rtl/bsram_pkg.sv
// Package: shared lane types and the lane-mask rule for the burst SRAM control.
// Assumes active-low write controls; global enable overrides per-lane strobes.
package bsram_pkg;
    localparam int LANE_W = 8;

    // Lane mask for a write-capable edge: global wins, else byte enable AND lane strobe.
    function automatic logic [3:0] lane_mask4(input logic gwe_n, input logic bwe_n,
                                              input logic [3:0] lane_n);
        if (!gwe_n)
            return 4'b1111;
        else if (!bwe_n)
            return ~lane_n;
        else
            return 4'b0000;
    endfunction
endpackage

// File: rtl/bsram_cmd_decode.sv
// Module: edge classifier and write/output-enable decode.
// Classifies each edge as processor start, controller start, continuation or
// deselect, and keeps the burst-open and last-edge-wrote flags.
// Assumes the address sequencer acts on burst_adv.
module bsram_cmd_decode
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             p_strobe_n,
    input  logic             c_strobe_n,
    input  logic             adv_n,
    input  logic             gwe_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             oe_n,
    input  logic             sel,
    output logic [LANES-1:0] byte_we,
    output logic             din_load,
    output logic             burst_adv,
    output logic             dq_oe
);
    logic p_start, c_start, cont, drop, wr_edge;
    logic open_q, wrote_q;
    logic [LANES-1:0] mask;

    // Classify the current edge from the strobes, select and burst state.
    always_comb begin
        p_start = !p_strobe_n && sel;
        c_start = !c_strobe_n && p_strobe_n && sel;
        cont    = p_strobe_n && c_strobe_n && open_q;
        drop    = (!p_strobe_n || !c_strobe_n) && !sel;
        wr_edge = c_start || cont;
    end

    // Per-lane write enables: zero except on controller starts and continuations.
    generate
        if (LANES == 4) begin : g_mask4
            always_comb mask = wr_edge ? lane_mask4(gwe_n, bwe_n, lane_n) : '0;
        end else begin : g_maskn
            always_comb begin
                if (!wr_edge)       mask = '0;
                else if (!gwe_n)    mask = '1;
                else if (!bwe_n)    mask = ~lane_n;
                else                mask = '0;
            end
        end
    endgenerate

    // Drive the edge-level outputs.
    always_comb begin
        byte_we   = mask;
        din_load  = |mask;
        burst_adv = cont && !adv_n;
        dq_oe     = open_q && !oe_n && !wrote_q;
    end

    // Track whether a burst is open.
    always_ff @(posedge clk) begin
        if (!rst_n)                 open_q <= 1'b0;
        else if (p_start || c_start) open_q <= 1'b1;
        else if (drop)              open_q <= 1'b0;
    end

    // Remember whether the last edge wrote any lane (forces the bus off).
    always_ff @(posedge clk) begin
        if (!rst_n) wrote_q <= 1'b0;
        else        wrote_q <= |mask;
    end

    // R1
    proc_start_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_strobe_n && sel) |-> (byte_we == '0 && !din_load));
    // R7
    bus_off_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|byte_we) |=> !dq_oe);
    // R9
    deselect_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_strobe_n && !sel) |=> !dq_oe);
    // R6
    no_adv_without_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_strobe_n || !c_strobe_n || adv_n) |-> !burst_adv);
endmodule

// File: rtl/bsram_lane_array.sv
// Module: lane-split storage array with flow-through read.
// Each byte lane is its own memory, written when its enable is high.
// Assumes one write port and one read address, both equal to wa.
module bsram_lane_array
    import bsram_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 4
) (
    input  logic                    clk,
    input  logic [AW-1:0]           wa,
    input  logic [LANES-1:0]        we,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];
            // Write this lane's byte when its enable is set.
            always_ff @(posedge clk) begin
                if (we[g]) mem[wa] <= wdata[g*LANE_W +: LANE_W];
            end
            // Flow-through read of this lane.
            always_comb rdata[g*LANE_W +: LANE_W] = mem[wa];
        end
    endgenerate
endmodule

// File: rtl/bsram_cycle_ctl.sv
// Module: top of the burst SRAM cycle and byte-write control.
// Joins the edge decoder and the lane array. Assumes wa comes from an
// external sequencer that steps on burst_adv.
module bsram_cycle_ctl
    import bsram_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 4,
    localparam int DW   = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             p_strobe_n,
    input  logic             c_strobe_n,
    input  logic             adv_n,
    input  logic             gwe_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             oe_n,
    input  logic             sel,
    input  logic [AW-1:0]    wa,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dq_oe,
    output logic [LANES-1:0] byte_we,
    output logic             din_load,
    output logic             burst_adv
);
    bsram_cmd_decode #(.LANES(LANES)) u_dec (
        .clk(clk), .rst_n(rst_n), .p_strobe_n(p_strobe_n), .c_strobe_n(c_strobe_n),
        .adv_n(adv_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_n(lane_n), .oe_n(oe_n),
        .sel(sel), .byte_we(byte_we), .din_load(din_load), .burst_adv(burst_adv),
        .dq_oe(dq_oe)
    );

    bsram_lane_array #(.LANES(LANES), .AW(AW)) u_arr (
        .clk(clk), .wa(wa), .we(byte_we), .wdata(din), .rdata(dout)
    );

    // R2
    global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_strobe_n && p_strobe_n && sel && !gwe_n) |-> (byte_we == '1));
    // R5
    load_tracks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_load == (byte_we != '0));
    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);
    // R8
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we == '1) |=> (dout == $past(din) || wa != $past(wa)));
endmodule

// File: tb/tb_bsram_cycle_ctl.sv
module tb_bsram_cycle_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p_strobe_n = 1'b1, c_strobe_n = 1'b1, adv_n = 1'b1, gwe_n = 1'b1, bwe_n = 1'b1;
    logic [3:0] lane_n = 4'hF;
    logic oe_n = 1'b1, sel = 1'b0;
    logic [3:0] wa = '0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic dq_oe, din_load, burst_adv;
    logic [3:0] byte_we;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [16];
    logic ex_open = 1'b0;
    logic ex_wrote = 1'b0;

    always #2 clk = ~clk;

    bsram_cycle_ctl dut (
        .clk(clk), .rst_n(rst_n), .p_strobe_n(p_strobe_n), .c_strobe_n(c_strobe_n),
        .adv_n(adv_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_n(lane_n), .oe_n(oe_n),
        .sel(sel), .wa(wa), .din(din), .dout(dout), .dq_oe(dq_oe), .byte_we(byte_we),
        .din_load(din_load), .burst_adv(burst_adv)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive, check edge outputs, clock, check registered outputs.
    task automatic apply(input logic p, input logic c, input logic adv, input logic g,
                         input logic b, input logic [3:0] ln, input logic oe,
                         input logic s, input logic [3:0] a, input logic [31:0] d,
                         input string req);
        logic ps, cs, ct, dr;
        logic [3:0] m;
        p_strobe_n = p; c_strobe_n = c; adv_n = adv; gwe_n = g; bwe_n = b;
        lane_n = ln; oe_n = oe; sel = s; wa = a; din = d;
        ps = !p && s;
        cs = !c && p && s;
        ct = p && c && ex_open;
        dr = (!p || !c) && !s;
        if (!(cs || ct)) m = 4'h0;
        else if (!g)     m = 4'hF;
        else if (!b)     m = ~ln;
        else             m = 4'h0;
        #1;
        check({req, " byte_we (R2 R3 R1)"}, {28'd0, byte_we}, {28'd0, m});
        check("R5 din_load", {31'd0, din_load}, {31'd0, |m});
        check("R6 burst_adv", {31'd0, burst_adv}, {31'd0, ct && !adv});
        @(posedge clk);
        for (int i = 0; i < 4; i++) if (m[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
        if (ps || cs) ex_open = 1'b1;
        else if (dr)  ex_open = 1'b0;
        ex_wrote = |m;
        @(negedge clk);
        check({req, " R7 dq_oe"}, {31'd0, dq_oe}, {31'd0, ex_open && !oe && !ex_wrote});
        check({req, " R8 dout"}, dout, model[a]);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        check("R10 dq_oe after reset", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b0; #1;
        check("R10 bus closed with oe low", {31'd0, dq_oe}, 32'd0);
        check("R10 no write on idle edge", {28'd0, byte_we}, 32'd0);
        @(negedge clk);
        // R4 fill every word with global writes on controller starts
        for (int a = 0; a < 16; a++)
            apply(1, 0, 1, 0, 1, 4'hF, 0, 1, a[3:0], 32'h1000_0000 * a + 32'h0102_0304,
                  "R4 fill");
        // R2 R3 R4 sweep on controller starts
        for (int k = 0; k < 64; k++) begin
            logic [5:0] v;
            v = k[5:0];
            apply(1, 0, 1, v[5], v[4], v[3:0], 0, 1, k[3:0], 32'hA5C3_0000 + k * 32'h0001_0101,
                  "R4 cstart");
            apply(1, 1, 1, 1, 1, 4'hF, 0, 1, k[3:0], 32'h0, "R7 idle");
        end
        // R2 R3 R6 sweep on continuation edges
        for (int k = 0; k < 64; k++) begin
            logic [5:0] v;
            v = k[5:0];
            apply(1, 1, k[0], v[5], v[4], v[3:0], 0, 1, 4'(k + 3), 32'h5A00_0000 ^ (k * 32'h0304_0506),
                  "R3 cont");
        end
        // R1 sweep on processor starts, controller strobe toggled too
        for (int k = 0; k < 64; k++) begin
            logic [5:0] v;
            v = k[5:0];
            apply(0, k[1], 1, v[5], v[4], v[3:0], k[2], 1, 4'(k), 32'hFFFF_FFFF, "R1 pstart");
        end
        // R4 both strobes low counts as processor start
        apply(0, 0, 1, 0, 0, 4'h0, 0, 1, 4'd7, 32'hDEAD_BEEF, "R4 both low");
        // R9 deselect closes the burst
        apply(1, 0, 1, 0, 0, 4'h0, 0, 0, 4'd2, 32'hBAD0_BAD0, "R9 deselect");
        apply(1, 1, 0, 0, 0, 4'h0, 0, 1, 4'd2, 32'hBAD1_BAD1, "R9 cont after close");
        apply(1, 1, 0, 1, 0, 4'h3, 0, 1, 4'd3, 32'hBAD2_BAD2, "R9 cont after close 2");
        // R6 reopen with processor start then advance
        apply(0, 1, 0, 1, 1, 4'hF, 0, 1, 4'd4, 32'h0, "R6 open");
        apply(1, 1, 0, 1, 1, 4'hF, 0, 1, 4'd5, 32'h0, "R6 adv");
        apply(1, 1, 1, 1, 1, 4'hF, 1, 1, 4'd6, 32'h0, "R7 oe high");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule